// File: doc/BRIEF.md
# Indirect BAR Access Window

This block gives a host an indirect path from configuration space into the register space behind a device's BARs. The host first sets up a window by writing three fields: the BAR number, an access size in bytes and a byte offset inside that BAR. It then reads or writes a 32-bit data field. Each data access is checked against a small table of capability descriptors. A data access that passes the check becomes one cycle on a simple request/acknowledge register bus. A data access that fails the check never reaches the bus and sets a sticky error flag.

Each descriptor holds a valid bit, a type code, a BAR number, a start offset and a byte length. A descriptor permits a window only if all of these hold: it is valid, its type is not the window's own configuration-access type, its BAR matches the window's BAR, and its range fully contains the window. The window must also use a size of 1, 2 or 4 bytes, and its offset must be a multiple of that size. Data travels in the low byte lanes of the 32-bit data field, and the block derives the bus byte enables from the size.

The host starts an access with a one-cycle pulse of `hostRe` or `hostWe` together with a field select. It then waits for the one-cycle `hostReady` pulse. The descriptor table is loaded through a separate static configuration port, and reset clears every valid bit.

Top module: `bar_window`

## Requirements
- R1: After reset, the BAR, size and offset fields read as zero, `errFlag` is 0, `busReq` is 0 and `hostReady` is 0.
- R2: The field select is encoded as 0 = BAR (3 bits, low lanes), 1 = size (32 bits), 2 = offset (32 bits) and 3 = data. A field write is read back unchanged by a later read of the same select.
- R3: A legal data read raises `busReq` with `busWe`=0, `busBar` equal to the BAR field and `busAddr` equal to the offset. `busBe` is 4'b0001, 4'b0011 or 4'b1111 for size 1, 2 or 4. The returned `hostRdata` is `busRdata` captured at the acknowledge, with bytes above the size forced to zero.
- R4: A legal data write raises `busReq` with `busWe`=1, the same address, BAR and byte enables as R3, and `busWdata` equal to the host's write data.
- R5: `busReq` stays high, with a stable address, until `busAck` is sampled. `hostReady` pulses for exactly one cycle, on the cycle after the acknowledge. For field accesses and blocked accesses, it pulses on the cycle after the request.
- R6: A data access whose offset is not a multiple of the size is blocked.
- R7: A data access with a size other than 1, 2 or 4 is blocked.
- R8: A data access is blocked unless offset through offset+size-1 lies inside one descriptor's range on the same BAR. A window that only partly overlaps a range is blocked, and so is a window on a different BAR.
- R9: A descriptor whose type equals the configuration-access type (`CFG_TYPE`) never permits an access.
- R10: Range ends are computed as 33-bit sums. A window ending exactly at 2^32 is legal, and a descriptor running past 2^32 does not wrap round to permit low offsets.
- R11: A blocked read returns zero. A blocked write issues no bus cycle. Both set `errFlag`, which stays set until reset, including across later legal accesses.
- R12: A descriptor loaded with its valid bit cleared permits nothing, even when it was valid before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Descriptor table write strobe |
| cfgIdx | input | $clog2(NUM_DESC) | Descriptor slot |
| cfgValid | input | 1 | Valid bit for the written slot |
| cfgType | input | TYPE_W | Descriptor type code |
| cfgBar | input | BAR_W | Descriptor BAR number |
| cfgOff | input | 32 | Descriptor start offset |
| cfgLen | input | 32 | Descriptor length in bytes |
| hostRe | input | 1 | Host read pulse |
| hostWe | input | 1 | Host write pulse |
| hostSel | input | 2 | Field select |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid with hostReady |
| hostReady | output | 1 | Access complete pulse |
| errFlag | output | 1 | Sticky blocked-access flag |
| busReq | output | 1 | Bus request |
| busWe | output | 1 | Bus write direction |
| busBar | output | BAR_W | Target BAR |
| busAddr | output | 32 | Byte offset in BAR |
| busBe | output | 4 | Byte enables |
| busWdata | output | 32 | Bus write data |
| busAck | input | 1 | Bus acknowledge |
| busRdata | input | 32 | Bus read data |

## Verification
The bench builds the block with `NUM_DESC`=4, `BAR_W`=3 and `CFG_TYPE`=5, so every slot of the table is used. With all four slots filled, one test setup covers the following at once: a permitting range, a configuration-access descriptor covering a whole BAR, a range reaching the top of the address space, and a slot that is later invalidated. Blocked cases are run from a fresh reset each time, so that the sticky flag rising can be attributed to one cause.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [1:0] {
    SEL_BAR  = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_OFF  = 2'd2,
    SEL_DATA = 2'd3
  } bwSel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } bwState_e;

  typedef struct packed {
    logic fieldWr;
    logic capField;
    logic capData;
    logic clrData;
    logic setErr;
    logic launch;
  } bwStrobe_t;
endpackage

// File: rtl/bw_datapath.sv
module bw_datapath
  import bw_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int TYPE_W = 8,
  parameter int BAR_W = 3,
  parameter logic [TYPE_W-1:0] CFG_TYPE = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [$clog2(NUM_DESC)-1:0] cfgIdx,
  input  logic                        cfgValid,
  input  logic [TYPE_W-1:0]           cfgType,
  input  logic [BAR_W-1:0]            cfgBar,
  input  logic [31:0]                 cfgOff,
  input  logic [31:0]                 cfgLen,
  input  logic [1:0]                  hostSel,
  input  logic [31:0]                 hostWdata,
  input  bwStrobe_t                   stb,
  output logic                        legal,
  output logic [31:0]                 hostRdata,
  output logic                        errFlag,
  output logic [BAR_W-1:0]            busBar,
  output logic [31:0]                 busAddr,
  output logic [31:0]                 busWdata,
  output logic [3:0]                  busBe,
  input  logic [31:0]                 busRdata
);
  localparam int IDX_W = $clog2(NUM_DESC);

  logic [NUM_DESC-1:0] descValid;
  logic [TYPE_W-1:0]   descType [NUM_DESC];
  logic [BAR_W-1:0]    descBar  [NUM_DESC];
  logic [31:0]         descOff  [NUM_DESC];
  logic [31:0]         descLen  [NUM_DESC];

  logic [BAR_W-1:0] winBar;
  logic [31:0]      winLen;
  logic [31:0]      winOff;
  logic [31:0]      wdataQ;

  // Descriptor table: valid bits reset, payload is static configuration
  always_ff @(posedge clk) begin
    if (!rstN) descValid <= '0;
    else if (cfgWe) descValid[cfgIdx] <= cfgValid;
  end

  always_ff @(posedge clk) begin
    if (cfgWe) begin
      descType[cfgIdx] <= cfgType;
      descBar[cfgIdx]  <= cfgBar;
      descOff[cfgIdx]  <= cfgOff;
      descLen[cfgIdx]  <= cfgLen;
    end
  end

  // Window fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winBar <= '0;
      winLen <= '0;
      winOff <= '0;
    end else if (stb.fieldWr) begin
      case (hostSel)
        SEL_BAR: winBar <= hostWdata[BAR_W-1:0];
        SEL_LEN: winLen <= hostWdata;
        SEL_OFF: winOff <= hostWdata;
        default: ;
      endcase
    end
  end

  // Legality check
  logic        lenOk;
  logic        alignOk;
  logic [32:0] winEnd;
  logic [NUM_DESC-1:0] hit;

  assign lenOk   = (winLen == 32'd1) || (winLen == 32'd2) || (winLen == 32'd4);
  assign alignOk = (winOff & (winLen - 32'd1)) == 32'd0;
  assign winEnd  = {1'b0, winOff} + {1'b0, winLen};

  for (genvar g = 0; g < NUM_DESC; g++) begin : gHit
    logic [32:0] descEnd;
    assign descEnd = {1'b0, descOff[g]} + {1'b0, descLen[g]};
    assign hit[g] = descValid[g] && (descType[g] != CFG_TYPE) &&
                    (descBar[g] == winBar) && (winOff >= descOff[g]) &&
                    (winEnd <= descEnd);
  end

  assign legal = lenOk && alignOk && (|hit);

  // Byte lane steering
  logic [31:0] laneMask;
  always_comb begin
    case (winLen[2:0])
      3'd1:    busBe = 4'b0001;
      3'd2:    busBe = 4'b0011;
      default: busBe = 4'b1111;
    endcase
    for (int b = 0; b < 4; b++) laneMask[8*b +: 8] = {8{busBe[b]}};
  end

  assign busBar   = winBar;
  assign busAddr  = winOff;
  assign busWdata = wdataQ;

  always_ff @(posedge clk) begin
    if (stb.launch) wdataQ <= hostWdata;
  end

  logic [31:0] fieldRdata;
  always_comb begin
    case (hostSel)
      SEL_BAR: fieldRdata = 32'(winBar);
      SEL_LEN: fieldRdata = winLen;
      SEL_OFF: fieldRdata = winOff;
      default: fieldRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostRdata <= '0;
    else if (stb.capField) hostRdata <= fieldRdata;
    else if (stb.capData) hostRdata <= busRdata & laneMask;
    else if (stb.clrData) hostRdata <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else if (stb.setErr) errFlag <= 1'b1;
  end

  logic unusedIdx;
  assign unusedIdx = ^IDX_W;
endmodule

// File: rtl/bw_control.sv
module bw_control
  import bw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostRe,
  input  logic      hostWe,
  input  logic [1:0] hostSel,
  input  logic      legal,
  input  logic      busAck,
  output bwStrobe_t stb,
  output logic      busReq,
  output logic      busWe,
  output logic      hostReady
);
  bwState_e state, stateNext;
  logic     dirWr;

  always_comb begin
    stb = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (hostRe || hostWe) begin
          if (hostSel != SEL_DATA) begin
            stb.fieldWr  = hostWe;
            stb.capField = hostRe && !hostWe;
            stb.clrData  = hostWe;
            stateNext    = ST_DONE;
          end else if (legal) begin
            stb.launch = 1'b1;
            stateNext  = ST_BUS;
          end else begin
            stb.setErr  = 1'b1;
            stb.clrData = 1'b1;
            stateNext   = ST_DONE;
          end
        end
      end
      ST_BUS: begin
        if (busAck) begin
          stb.capData = !dirWr;
          stb.clrData = dirWr;
          stateNext   = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      dirWr <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.launch) dirWr <= hostWe;
    end
  end

  assign busReq    = (state == ST_BUS);
  assign busWe     = dirWr;
  assign hostReady = (state == ST_DONE);
endmodule

// File: rtl/bar_window.sv
module bar_window
  import bw_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int TYPE_W = 8,
  parameter int BAR_W = 3,
  parameter logic [TYPE_W-1:0] CFG_TYPE = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [$clog2(NUM_DESC)-1:0] cfgIdx,
  input  logic                        cfgValid,
  input  logic [TYPE_W-1:0]           cfgType,
  input  logic [BAR_W-1:0]            cfgBar,
  input  logic [31:0]                 cfgOff,
  input  logic [31:0]                 cfgLen,
  input  logic                        hostRe,
  input  logic                        hostWe,
  input  logic [1:0]                  hostSel,
  input  logic [31:0]                 hostWdata,
  output logic [31:0]                 hostRdata,
  output logic                        hostReady,
  output logic                        errFlag,
  output logic                        busReq,
  output logic                        busWe,
  output logic [BAR_W-1:0]            busBar,
  output logic [31:0]                 busAddr,
  output logic [3:0]                  busBe,
  output logic [31:0]                 busWdata,
  input  logic                        busAck,
  input  logic [31:0]                 busRdata
);
  bwStrobe_t stb;
  logic      legal;

  bw_control u_ctrl (
    .clk(clk), .rstN(rstN), .hostRe(hostRe), .hostWe(hostWe),
    .hostSel(hostSel), .legal(legal), .busAck(busAck), .stb(stb),
    .busReq(busReq), .busWe(busWe), .hostReady(hostReady)
  );

  bw_datapath #(
    .NUM_DESC(NUM_DESC), .TYPE_W(TYPE_W), .BAR_W(BAR_W), .CFG_TYPE(CFG_TYPE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgValid(cfgValid), .cfgType(cfgType), .cfgBar(cfgBar),
    .cfgOff(cfgOff), .cfgLen(cfgLen), .hostSel(hostSel),
    .hostWdata(hostWdata), .stb(stb), .legal(legal),
    .hostRdata(hostRdata), .errFlag(errFlag), .busBar(busBar),
    .busAddr(busAddr), .busWdata(busWdata), .busBe(busBe),
    .busRdata(busRdata)
  );
endmodule

// File: rtl/bw_checker.sv
module bw_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busReq,
  input logic        busAck,
  input logic [31:0] busAddr,
  input logic [3:0]  busBe,
  input logic        errFlag,
  input logic        hostReady
);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr));

  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady);

  p_ack_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |=> hostReady && !busReq);

  p_be_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busBe == 4'b0001 || busBe == 4'b0011 || busBe == 4'b1111));

  p_word_align_r6: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busBe == 4'b1111 |-> busAddr[1:0] == 2'b00);

  p_half_align_r6: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busBe == 4'b0011 |-> busAddr[0] == 1'b0);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

bind bar_window bw_checker u_bwChk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busAck(busAck),
  .busAddr(busAddr), .busBe(busBe), .errFlag(errFlag), .hostReady(hostReady)
);

// File: tb/bar_window_bench.sv
module bar_window_bench;
  localparam int NUM_DESC = 4;
  localparam int BAR_W = 3;
  localparam int TYPE_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgIdx = '0;
  logic cfgValid = 1'b0;
  logic [TYPE_W-1:0] cfgType = '0;
  logic [BAR_W-1:0] cfgBar = '0;
  logic [31:0] cfgOff = '0, cfgLen = '0;
  logic hostRe = 1'b0, hostWe = 1'b0;
  logic [1:0] hostSel = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic hostReady, errFlag, busReq, busWe;
  logic [BAR_W-1:0] busBar;
  logic [31:0] busAddr, busWdata;
  logic [3:0] busBe;
  logic busAck = 1'b0;
  logic [31:0] busRdata = '0;

  int errors = 0;
  int checks = 0;

  typedef struct {
    bit          isRead;
    logic [31:0] data;
    string       tag;
  } hostItem_t;

  typedef struct {
    bit               we;
    logic [BAR_W-1:0] bar;
    logic [31:0]      addr;
    logic [3:0]       be;
    logic [31:0]      wdata;
    string            tag;
  } busItem_t;

  hostItem_t hostQ[$];
  busItem_t  busQ[$];

  always #2.5 clk = ~clk;

  bar_window #(.NUM_DESC(NUM_DESC), .TYPE_W(TYPE_W), .BAR_W(BAR_W), .CFG_TYPE(8'd5)) u_bar_window (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgValid(cfgValid),
    .cfgType(cfgType), .cfgBar(cfgBar), .cfgOff(cfgOff), .cfgLen(cfgLen),
    .hostRe(hostRe), .hostWe(hostWe), .hostSel(hostSel), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostReady(hostReady), .errFlag(errFlag),
    .busReq(busReq), .busWe(busWe), .busBar(busBar), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata)
  );

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return a ^ 32'hC3A5_5A3C;
  endfunction

  function automatic logic [31:0] lenMask(input logic [31:0] len);
    return (len == 1) ? 32'h0000_00FF : (len == 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] lenBe(input logic [31:0] len);
    return (len == 1) ? 4'b0001 : (len == 2) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: host completions
  always @(negedge clk) begin
    if (rstN && hostReady) begin
      if (hostQ.size() == 0) begin
        check(1'b0, "R5 unexpected hostReady", 32'd1, 32'd0);
      end else begin
        hostItem_t it;
        it = hostQ.pop_front();
        if (it.isRead) check(hostRdata == it.data, it.tag, hostRdata, it.data);
      end
    end
  end

  // Bus responder and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && busReq) begin
        if (busQ.size() == 0) begin
          check(1'b0, "R11 unexpected bus cycle", busAddr, 32'd0);
        end else begin
          busItem_t b;
          b = busQ.pop_front();
          check(busWe == b.we && busBar == b.bar && busAddr == b.addr && busBe == b.be,
                {b.tag, " bus attrs"}, {busWe, 3'(busBar), busBe, busAddr[23:0]},
                {b.we, 3'(b.bar), b.be, b.addr[23:0]});
          if (b.we) check(busWdata == b.wdata, {b.tag, " wdata"}, busWdata, b.wdata);
        end
        @(negedge clk);
        check(busReq == 1'b1, "R5 req held", 32'(busReq), 32'd1);
        busAck = 1'b1;
        busRdata = pattern(busAddr);
        @(negedge clk);
        busAck = 1'b0;
      end
    end
  end

  task automatic hostAccess(input bit wr, input logic [1:0] sel, input logic [31:0] wd,
                            input logic [31:0] expRd, input string tag);
    hostItem_t it;
    it.isRead = !wr; it.data = expRd; it.tag = tag;
    hostQ.push_back(it);
    @(negedge clk);
    hostRe = !wr; hostWe = wr; hostSel = sel; hostWdata = wd;
    @(negedge clk);
    hostRe = 1'b0; hostWe = 1'b0;
    while (!hostReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setWin(input logic [2:0] bar, input logic [31:0] len, input logic [31:0] off);
    hostAccess(1'b1, 2'd0, 32'(bar), 32'd0, "R2 bar wr");
    hostAccess(1'b1, 2'd1, len, 32'd0, "R2 len wr");
    hostAccess(1'b1, 2'd2, off, 32'd0, "R2 off wr");
  endtask

  task automatic legalAcc(input bit wr, input logic [2:0] bar, input logic [31:0] len,
                          input logic [31:0] off, input logic [31:0] wd, input string tag);
    busItem_t b;
    setWin(bar, len, off);
    b.we = wr; b.bar = bar; b.addr = off; b.be = lenBe(len); b.wdata = wd; b.tag = tag;
    busQ.push_back(b);
    hostAccess(wr, 2'd3, wd, wr ? 32'd0 : (pattern(off) & lenMask(len)), tag);
  endtask

  task automatic loadDesc(input int idx, input bit v, input logic [7:0] t, input logic [2:0] bar,
                          input logic [31:0] off, input logic [31:0] len);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 2'(idx); cfgValid = v; cfgType = t; cfgBar = bar;
    cfgOff = off; cfgLen = len;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    loadDesc(0, 1'b1, 8'd1, 3'd2, 32'h100, 32'h20);
    loadDesc(1, 1'b1, 8'd5, 3'd1, 32'h0, 32'h1000);
    loadDesc(2, 1'b1, 8'd2, 3'd0, 32'hFFFF_FFF0, 32'h10);
    loadDesc(3, 1'b1, 8'd3, 3'd3, 32'h40, 32'h10);
  endtask

  task automatic blocked(input bit wr, input logic [2:0] bar, input logic [31:0] len,
                         input logic [31:0] off, input string tag);
    doReset();
    setWin(bar, len, off);
    check(errFlag == 1'b0, {tag, " err clear before"}, 32'(errFlag), 32'd0);
    hostAccess(wr, 2'd3, 32'h1234_5678, 32'd0, {tag, " blocked data"});
    check(errFlag == 1'b1, {tag, " err set (R11)"}, 32'(errFlag), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busReq == 1'b0, "R1 busReq", 32'(busReq), 32'd0);
    check(hostReady == 1'b0, "R1 hostReady", 32'(hostReady), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(errFlag == 1'b0, "R1 errFlag", 32'(errFlag), 32'd0);
    hostAccess(1'b0, 2'd0, 0, 32'd0, "R1 bar field");
    hostAccess(1'b0, 2'd1, 0, 32'd0, "R1 len field");
    hostAccess(1'b0, 2'd2, 0, 32'd0, "R1 off field");

    doReset();
    // R2 field readback
    setWin(3'd2, 32'd4, 32'h104);
    hostAccess(1'b0, 2'd0, 0, 32'd2, "R2 bar rd");
    hostAccess(1'b0, 2'd1, 0, 32'd4, "R2 len rd");
    hostAccess(1'b0, 2'd2, 0, 32'h104, "R2 off rd");

    // R3 reads of each size, R4 writes
    legalAcc(1'b0, 3'd2, 32'd4, 32'h104, 0, "R3 word read");
    legalAcc(1'b0, 3'd2, 32'd2, 32'h11E, 0, "R3 half read");
    legalAcc(1'b0, 3'd2, 32'd1, 32'h101, 0, "R3 byte read");
    legalAcc(1'b1, 3'd2, 32'd1, 32'h11F, 32'hDEAD_BE77, "R4 byte write");
    legalAcc(1'b1, 3'd2, 32'd4, 32'h11C, 32'hCAFE_F00D, "R4 word write at range end");
    // R10 window ending at 2^32
    legalAcc(1'b0, 3'd0, 32'd4, 32'hFFFF_FFFC, 0, "R10 top-of-space read");
    legalAcc(1'b0, 3'd3, 32'd4, 32'h4C, 0, "R12 valid slot read");
    check(errFlag == 1'b0, "R11 no err after legal", 32'(errFlag), 32'd0);

    blocked(1'b0, 3'd2, 32'd4, 32'h102, "R6 misaligned word");
    blocked(1'b1, 3'd2, 32'd2, 32'h105, "R6 misaligned half");
    blocked(1'b0, 3'd2, 32'd3, 32'h100, "R7 size 3");
    blocked(1'b1, 3'd2, 32'd8, 32'h100, "R7 size 8");
    blocked(1'b0, 3'd2, 32'd4, 32'h120, "R8 past range");
    blocked(1'b0, 3'd2, 32'd4, 32'hFC, "R8 before range");
    blocked(1'b1, 3'd4, 32'd4, 32'h104, "R8 wrong bar");
    blocked(1'b0, 3'd1, 32'd4, 32'h10, "R9 cfg type only");
    blocked(1'b0, 3'd0, 32'd4, 32'h4, "R10 no wrap");

    // R12 invalidated slot
    doReset();
    loadDesc(3, 1'b0, 8'd3, 3'd3, 32'h40, 32'h10);
    setWin(3'd3, 32'd4, 32'h4C);
    hostAccess(1'b0, 2'd3, 0, 32'd0, "R12 invalid slot read");
    check(errFlag == 1'b1, "R12 err set", 32'(errFlag), 32'd1);

    // R11 sticky across a later legal access
    legalAcc(1'b0, 3'd2, 32'd4, 32'h108, 0, "R11 legal after error");
    check(errFlag == 1'b1, "R11 err sticky", 32'(errFlag), 32'd1);

    repeat (4) @(negedge clk);
    check(hostQ.size() == 0, "R5 all host items done", hostQ.size(), 0);
    check(busQ.size() == 0, "R3 all bus items seen", busQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule